// File: doc/BRIEF.md
# Two-Core MSI Snooping Cache Pair

This block holds two small private caches, one per core, and keeps them coherent over one shared snooping bus in front of a flat backing memory. Each cache is write-back and fully associative, with a few word-sized lines. Every line is Invalid, Shared (read-only, possibly also held by the peer) or Modified (readable and writable, held by this cache alone).

A core presents a request with a read/write flag, an address and write data, and holds it until `req_ready` rises. A request that the local line already permits completes in the cycle it is presented. Otherwise the cache asks for the bus. A read miss issues GetS, and a write miss or a write to a Shared line issues GetM. A round-robin arbiter grants one transaction per cycle, and the transaction completes atomically at that clock edge. The peer snoops it: a Modified peer writes its data back and either drops to Shared (on GetS) or to Invalid (on GetM), and a Shared peer drops to Invalid on GetM. The requester fills from the freshest data. When it must free a slot it may evict a line, and an evicted Modified line is written back. The retried request then hits on the next cycle.

Top module: `msi_pair_top`

## Requirements
- R1: After reset every line is Invalid and every memory word is zero, so the first read of any address misses and returns 0.
- R2: A read to a Shared or Modified line, or a write to a Modified line, raises `req_ready` in the same cycle as `req_valid`, with no bus transaction; read data is on `rsp_rdata` in that cycle.
- R3: At every address, either one cache holds the line Modified and the other holds it Invalid, or neither holds it Modified; a cache never holds two valid lines for one address.
- R4: A read miss issues GetS; a Modified peer copy is written back to memory and drops to Shared, and both copies then hold the same value.
- R5: A write miss or a write to a Shared line issues GetM before the store; every peer copy becomes Invalid, and a Modified peer writes back first.
- R6: A read returns the value of the most recent write to that address by either core, and every Shared copy equals the memory word at its address.
- R7: A store to a Modified line changes only the local copy, and a Modified line that is evicted to make room is written back, so that later reads by the other core see its value.
- R8: At most one bus transaction is granted per cycle, only to a core whose request misses. After reset core 0 wins a tie. After that, a tie goes to the core that was not granted last.
- R9: A granted request that is still presented unchanged in the next cycle completes in that cycle, so an uncontended miss completes on the second cycle it is presented.
- R10: When both cores write the same address in the same cycle, the later-granted store is ordered after the earlier one and its value is the one that survives.
- R11: A core that keeps reading an address that the other core writes eventually reads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Per-core request present, held until ready |
| req_write | input | 2 | Per-core 1 = store, 0 = load |
| req_addr | input | 2 x AW | Per-core word address |
| req_wdata | input | 2 x DW | Per-core store data |
| req_ready | output | 2 | Per-core request completes this cycle |
| rsp_rdata | output | 2 x DW | Per-core load data, valid while ready |

## Verification
A hit is due in the cycle it is presented. An uncontended miss is due one cycle later, because the bus transaction commits at the first edge and the retry hits. When both cores miss together, the core that loses arbitration waits one more cycle. The bench drives each request on a falling edge and samples `req_ready` a moment later, in the same low phase. It counts those phases as the latency and compares that count with the value each requirement predicts. Data is read at the same moment and compared with a model of the last write in grant order.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_e;

    typedef enum logic {
        BUS_GETS = 1'b0,
        BUS_GETM = 1'b1
    } bus_op_e;
endpackage

// File: rtl/msi_rr_arb.sv
module msi_rr_arb #(
    parameter int N  = 2,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);
    typedef struct packed {
        logic [IW-1:0] last;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        arb_d   = arb_q;
        gnt     = '0;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            int cand;
            cand = (int'(arb_q.last) + 1 + k) % N;
            if (!gnt_vld && req[cand]) begin
                gnt_vld   = 1'b1;
                gnt_idx   = IW'(cand);
                gnt[cand] = 1'b1;
            end
        end
        if (gnt_vld) arb_d.last = gnt_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '{last: IW'(N - 1)};
        else        arb_q <= arb_d;
    end

    AST_GNT_ONE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R8
    AST_GNT_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0); // R8
endmodule

// File: rtl/msi_line_lookup.sv
module msi_line_lookup
    import msi_pkg::*;
#(
    parameter int LINES = 2,
    parameter int AW    = 4,
    parameter int IW    = $clog2(LINES)
) (
    input  line_st_e [LINES-1:0]         st,
    input  logic     [LINES-1:0][AW-1:0] tag,
    input  logic     [AW-1:0]            req_addr,
    input  logic     [AW-1:0]            snp_addr,
    input  logic     [IW-1:0]            vptr,
    output logic                         req_hit,
    output logic     [IW-1:0]            req_idx,
    output logic                         snp_hit,
    output logic     [IW-1:0]            snp_idx,
    output logic     [IW-1:0]            fill_idx,
    output logic                         fill_by_ptr
);
    logic          free_any;
    logic [IW-1:0] free_idx;

    always_comb begin
        req_hit  = 1'b0;
        req_idx  = '0;
        snp_hit  = 1'b0;
        snp_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (st[i] != LN_INV && tag[i] == req_addr) begin
                req_hit = 1'b1;
                req_idx = IW'(i);
            end
            if (st[i] != LN_INV && tag[i] == snp_addr) begin
                snp_hit = 1'b1;
                snp_idx = IW'(i);
            end
            if (st[i] == LN_INV) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
        end
        fill_by_ptr = 1'b0;
        if (req_hit)       fill_idx = req_idx;
        else if (free_any) fill_idx = free_idx;
        else begin
            fill_idx    = vptr;
            fill_by_ptr = 1'b1;
        end
    end
endmodule

// File: rtl/msi_pair_top.sv
module msi_pair_top
    import msi_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DW    = 8,
    parameter int LINES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         req_valid,
    input  logic [1:0]         req_write,
    input  logic [1:0][AW-1:0] req_addr,
    input  logic [1:0][DW-1:0] req_wdata,
    output logic [1:0]         req_ready,
    output logic [1:0][DW-1:0] rsp_rdata
);
    localparam int NC    = 2;
    localparam int CW    = $clog2(NC);
    localparam int DEPTH = 1 << AW;
    localparam int IW    = $clog2(LINES);

    typedef struct packed {
        line_st_e [NC-1:0][LINES-1:0]         st;
        logic     [NC-1:0][LINES-1:0][AW-1:0] tag;
        logic     [NC-1:0][LINES-1:0][DW-1:0] dat;
        logic     [DEPTH-1:0][DW-1:0]         mem;
        logic     [NC-1:0][IW-1:0]            vptr;
    } state_t;

    state_t st_d, st_q;

    logic [NC-1:0]         rq_hit, sn_hit, fill_by_ptr, perm, bus_req, gnt;
    logic [NC-1:0][IW-1:0] rq_idx, sn_idx, fill_idx;
    logic                  gnt_vld;
    logic [CW-1:0]         gnt_idx, peer;
    logic [AW-1:0]         bus_addr;
    bus_op_e               bus_op;
    logic [DW-1:0]         fresh;

    assign bus_addr = req_addr[gnt_idx];
    assign peer     = ~gnt_idx;

    for (genvar c = 0; c < NC; c++) begin : g_look
        msi_line_lookup #(.LINES(LINES), .AW(AW), .IW(IW)) u_look (
            .st(st_q.st[c]), .tag(st_q.tag[c]),
            .req_addr(req_addr[c]), .snp_addr(bus_addr), .vptr(st_q.vptr[c]),
            .req_hit(rq_hit[c]), .req_idx(rq_idx[c]),
            .snp_hit(sn_hit[c]), .snp_idx(sn_idx[c]),
            .fill_idx(fill_idx[c]), .fill_by_ptr(fill_by_ptr[c])
        );

        AST_MISS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[c] ##1 (req_valid[c] && $stable(req_addr[c]) && $stable(req_write[c]))
            |-> req_ready[c]); // R9
        AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
            req_ready[c] |-> (req_valid[c] && !gnt[c])); // R2
    end

    msi_rr_arb #(.N(NC), .IW(CW)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(bus_req),
        .gnt(gnt), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    always_comb begin
        st_d      = st_q;
        req_ready = '0;
        bus_op    = BUS_GETS;
        fresh     = '0;
        // local hits complete first; the bus transaction is ordered after them
        for (int c = 0; c < NC; c++) begin
            rsp_rdata[c] = st_q.dat[c][rq_idx[c]];
            perm[c]      = rq_hit[c] && (!req_write[c] || st_q.st[c][rq_idx[c]] == LN_MOD);
            bus_req[c]   = req_valid[c] && !perm[c];
            if (req_valid[c] && perm[c]) begin
                req_ready[c] = 1'b1;
                if (req_write[c]) st_d.dat[c][rq_idx[c]] = req_wdata[c];
            end
        end
        if (gnt_vld) begin
            bus_op = req_write[gnt_idx] ? BUS_GETM : BUS_GETS;
            fresh  = st_q.mem[bus_addr];
            if (sn_hit[peer]) begin
                if (st_q.st[peer][sn_idx[peer]] == LN_MOD) begin
                    fresh                         = st_d.dat[peer][sn_idx[peer]];
                    st_d.mem[bus_addr]            = fresh;
                    st_d.st[peer][sn_idx[peer]]   = (bus_op == BUS_GETM) ? LN_INV : LN_SHR;
                end else if (bus_op == BUS_GETM) begin
                    st_d.st[peer][sn_idx[peer]]   = LN_INV;
                end
            end
            if (st_q.st[gnt_idx][fill_idx[gnt_idx]] == LN_MOD)
                st_d.mem[st_q.tag[gnt_idx][fill_idx[gnt_idx]]] =
                    st_q.dat[gnt_idx][fill_idx[gnt_idx]];
            st_d.st[gnt_idx][fill_idx[gnt_idx]]  = (bus_op == BUS_GETM) ? LN_MOD : LN_SHR;
            st_d.tag[gnt_idx][fill_idx[gnt_idx]] = bus_addr;
            st_d.dat[gnt_idx][fill_idx[gnt_idx]] = fresh;
            if (fill_by_ptr[gnt_idx])
                st_d.vptr[gnt_idx] = (st_q.vptr[gnt_idx] == IW'(LINES - 1)) ? '0
                                   : st_q.vptr[gnt_idx] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic swmr_bad, shr_stale;
    always_comb begin
        swmr_bad  = 1'b0;
        shr_stale = 1'b0;
        for (int a = 0; a < NC; a++) begin
            for (int i = 0; i < LINES; i++) begin
                if (st_q.st[a][i] == LN_SHR && st_q.dat[a][i] != st_q.mem[st_q.tag[a][i]])
                    shr_stale = 1'b1;
                for (int b = 0; b < NC; b++) begin
                    for (int j = 0; j < LINES; j++) begin
                        if ((a != b || i != j) && st_q.st[a][i] != LN_INV &&
                            st_q.st[b][j] != LN_INV && st_q.tag[a][i] == st_q.tag[b][j] &&
                            (a == b || st_q.st[a][i] == LN_MOD))
                            swmr_bad = 1'b1;
                    end
                end
            end
        end
    end

    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n) !swmr_bad); // R3
    AST_SHARED_FRESH:  assert property (@(posedge clk) disable iff (!rst_n) !shr_stale); // R6
endmodule

// File: tb/msi_pair_top_tb.sv
module msi_pair_top_tb;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      req_valid = '0;
    logic [1:0]      req_write = '0;
    logic [1:0][3:0] req_addr = '0;
    logic [1:0][7:0] req_wdata = '0;
    logic [1:0]      req_ready;
    logic [1:0][7:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    msi_pair_top #(.AW(4), .DW(8), .LINES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic op(input int c, input bit w, input logic [3:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output int lat);
        @(negedge clk);
        req_write[c] = w;
        req_addr[c]  = a;
        req_wdata[c] = d;
        req_valid[c] = 1'b1;
        lat = 1;
        forever begin
            #1;
            if (req_ready[c] || lat > 50) break;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata[c];
        @(negedge clk);
        req_valid[c] = 1'b0;
    endtask

    function automatic logic [7:0] f1(input int a); return 8'(a * 7 + 1);    endfunction
    function automatic logic [7:0] f2(input int a); return 8'(a * 13 + 64); endfunction

    initial begin
        logic [7:0] r0, r1;
        int l0, l1;
        do_reset();
        #1;
        chk("R1 ready idle after reset", int'(req_ready), 0);

        // R1 R8: simultaneous misses after reset, core 0 first
        fork
            op(0, 1'b0, 4'd3, 8'h00, r0, l0);
            op(1, 1'b0, 4'd5, 8'h00, r1, l1);
        join
        chk("R1 core0 zero data", r0, 0);
        chk("R1 core1 zero data", r1, 0);
        chk("R8 core0 wins reset tie", l0, 2);
        chk("R8 core1 waits", l1, 3);
        op(0, 1'b0, 4'd11, 8'h00, r0, l0);
        chk("R9 uncontended miss latency", l0, 2);
        fork
            op(0, 1'b0, 4'd12, 8'h00, r0, l0);
            op(1, 1'b0, 4'd13, 8'h00, r1, l1);
        join
        chk("R8 core1 wins after core0 grant", l1, 2);
        chk("R8 core0 waits", l0, 3);

        // R10: same-address stores in the same cycle, core1 has priority
        fork
            op(0, 1'b1, 4'd6, 8'hA1, r0, l0);
            op(1, 1'b1, 4'd6, 8'hB2, r1, l1);
        join
        chk("R10 core1 store first", l1, 2);
        chk("R10 core0 store second", l0, 3);
        op(1, 1'b0, 4'd6, 8'h00, r1, l1);
        chk("R10 later store survives", r1, 8'hA1);
        chk("R5 peer invalidated by GetM", l1, 2);

        do_reset();
        for (int a = 0; a < 16; a++) begin
            op(0, 1'b1, 4'(a), f1(a), r0, l0);
            chk("R5 write miss latency", l0, 2);
            op(1, 1'b0, 4'(a), 8'h00, r1, l1);
            chk("R4 read sees modified peer data", r1, f1(a));
            chk("R4 read miss latency", l1, 2);
            op(0, 1'b0, 4'(a), 8'h00, r0, l0);
            chk("R4 owner kept shared copy", r0, f1(a));
            chk("R2 shared read hits", l0, 1);
            op(1, 1'b1, 4'(a), f2(a), r1, l1);
            chk("R5 upgrade from shared latency", l1, 2);
            op(1, 1'b0, 4'(a), 8'h00, r1, l1);
            chk("R2 modified read hits", l1, 1);
            chk("R7 local store data", r1, f2(a));
            op(0, 1'b0, 4'(a), 8'h00, r0, l0);
            chk("R6 read after peer upgrade", r0, f2(a));
            chk("R5 upgrade invalidated peer", l0, 2);
        end
        for (int a = 0; a < 16; a++) begin
            op(1, 1'b0, 4'(a), 8'h00, r1, l1);
            chk("R6 value after sweep", r1, f2(a));
        end

        // R7: third store evicts a modified line, which must be written back
        for (int a = 0; a < 3; a++) begin
            op(0, 1'b1, 4'(a), 8'(8'hC0 + a), r0, l0);
            chk("R7 store miss latency", l0, 2);
        end
        for (int a = 0; a < 3; a++) begin
            op(1, 1'b0, 4'(a), 8'h00, r1, l1);
            chk("R7 evicted value visible", r1, 8'hC0 + a);
        end

        // R11: spinning reader observes a store
        begin
            bit seen = 1'b0;
            fork
                begin
                    for (int n = 0; n < 20 && !seen; n++) begin
                        logic [7:0] rr;
                        int ll;
                        op(1, 1'b0, 4'd8, 8'h00, rr, ll);
                        if (rr == 8'h5C) seen = 1'b1;
                    end
                end
                begin
                    logic [7:0] rw;
                    int lw;
                    repeat (3) @(negedge clk);
                    op(0, 1'b1, 4'd8, 8'h5C, rw, lw);
                end
            join
            chk("R11 spinning reader sees store", int'(seen), 1);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule